// File: doc/BRIEF.md
# Transition-Locked Bit Clock Recovery

This block regenerates the bit-rate sampling clock for a codirectional serial receiver. An oversampling clock (2.048 MHz in the intended use, free-running and unrelated to any other clock) drives a divide counter. The counter's recovered clock has a nominal rate of one sixteenth of that clock, which is 128 kHz. The active-low positive rail of the dual-rail line data is brought into the oversampling domain. Each falling sample on that rail is a positive-going line transition. When such a transition lands close enough to the phase the counter expects, the counter is snapped back to a fixed reference phase.

If the line stops supplying transitions near the expected phase for a run of recovered periods, the block declares the alignment lost. It then enters a seek state and shortens its count by one, so that its phase slides past the data until any transition appears. The first transition seen in seek mode is accepted at once and brings the block back into lock. A downstream decoder samples the line on the rising edge of the recovered clock. The negative rail and all decoding are handled elsewhere.

Top module: `bitClkRecovery`

## Requirements
- R1: After reset the phase count is 0, `recClk` is 1 and `seekMode` is 1.
- R2: `posRailN` passes through two synchronizing flops. A 1-to-0 change sampled at rising clock edge k is acted on by the counter at edge k+2.
- R3: `recClk` is 1 while the phase count is in 0..7 and 0 while it is in 8 or above. It rises only when the count enters 0.
- R4: Without an accepted transition, the count wraps to 0 after 15 when locked (a 16-cycle period) and after 14 in seek mode (a 15-cycle period).
- R5: When locked, a transition is accepted only if it is seen while the count is within 6..10 (reference phase 8, window of 2 either side). An accepted transition sets the count to 9 on the next edge. A transition outside the window leaves the count free-running.
- R6: When locked, every wrap with no accepted transition since the previous wrap advances a miss count. The 16th such wrap in a row sets `seekMode`.
- R7: In seek mode any transition is accepted, whatever the count. This clears `seekMode` and restarts the count at 9.
- R8: A 0-to-1 change on `posRailN` is never treated as a transition. It neither restarts the count nor leaves seek mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oversampling clock (16x the bit rate) |
| rstN | input | 1 | Asynchronous active-low reset |
| posRailN | input | 1 | Positive line rail, active low, asynchronous to `clk` |
| recClk | output | 1 | Recovered bit clock; the decoder samples on its rising edge |
| seekMode | output | 1 | High while alignment is lost and the block is seeking |

## Verification
The bench builds the block with its default parameters: a 16-cycle locked period, a 15-cycle seek period, a window of 2 counts either side of phase 8, and a loss limit of 16 periods. With these values, jittered transition streams of period 13 to 19 regularly fall just inside and just outside the window. A few hundred silent cycles are enough to reach the loss threshold and to watch the shortened period slip the phase in seek mode. A cycle-level reference model checks both outputs on every cycle. Separate measurements of the recovered period confirm the 15- and 16-cycle lengths, and a directed sequence shows that rising rail changes do not end seek mode.

// File: rtl/bitClkPkg.sv
package bitClkPkg;
  // Strobes from the control to the counter datapath.
  typedef struct packed {
    logic restart;  // load the reference restart phase on the next edge
    logic seekLen;  // use the shortened count length
  } ctrlStrobes_t;
endpackage

// File: rtl/bitClkEdgeSync.sv
module bitClkEdgeSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic railN,
  output logic edgeSeen
);
  // pipe[SYNC_STAGES-1] is the synchronized sample; pipe[SYNC_STAGES] is its previous value.
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[SYNC_STAGES-1:0], railN};
  end

  // A falling active-low sample marks a positive-going line transition.
  assign edgeSeen = pipe[SYNC_STAGES] & ~pipe[SYNC_STAGES-1];
endmodule

// File: rtl/bitClkCtrl.sv
module bitClkCtrl
  import bitClkPkg::*;
#(
  parameter int DIV_LEN      = 16,
  parameter int EDGE_PHASE   = 8,
  parameter int WIN          = 2,
  parameter int LOSS_PERIODS = 16,
  localparam int CNT_W  = $clog2(DIV_LEN),
  localparam int MISS_W = $clog2(LOSS_PERIODS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             edgeSeen,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  output ctrlStrobes_t     strb,
  output logic             seekMode,
  output logic             accept,
  output logic [MISS_W-1:0] missCnt
);
  localparam logic [CNT_W-1:0]  WIN_LO    = CNT_W'(EDGE_PHASE - WIN);
  localparam logic [CNT_W-1:0]  WIN_HI    = CNT_W'(EDGE_PHASE + WIN);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_PERIODS - 1);

  logic inWindow;
  assign inWindow = (cnt >= WIN_LO) && (cnt <= WIN_HI);
  assign accept   = edgeSeen && (seekMode || inWindow);

  always_comb begin
    strb         = '0;
    strb.restart = accept;
    strb.seekLen = seekMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seekMode <= 1'b1;
      missCnt  <= '0;
    end else if (accept) begin
      seekMode <= 1'b0;
      missCnt  <= '0;
    end else if (seekMode) begin
      missCnt  <= '0;
    end else if (wrap) begin
      if (missCnt == MISS_LAST) begin
        seekMode <= 1'b1;
        missCnt  <= '0;
      end else begin
        missCnt  <= missCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitClkDatapath.sv
module bitClkDatapath
  import bitClkPkg::*;
#(
  parameter int DIV_LEN    = 16,
  parameter int SEEK_LEN   = 15,
  parameter int EDGE_PHASE = 8,
  localparam int CNT_W = $clog2(DIV_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             recClk
);
  localparam logic [CNT_W-1:0] LAST_LOCK = CNT_W'(DIV_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_SEEK = CNT_W'(SEEK_LEN - 1);
  localparam logic [CNT_W-1:0] RESTART   = CNT_W'((EDGE_PHASE + 1) % DIV_LEN);
  localparam logic [CNT_W-1:0] HALF      = CNT_W'(DIV_LEN / 2);

  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] cntNext;

  assign lastCnt = strb.seekLen ? LAST_SEEK : LAST_LOCK;
  assign wrap    = !strb.restart && (cnt == lastCnt);

  always_comb begin
    if (strb.restart)        cntNext = RESTART;
    else if (cnt == lastCnt) cntNext = '0;
    else                     cntNext = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      recClk <= 1'b1;
    end else begin
      cnt    <= cntNext;
      recClk <= (cntNext < HALF);
    end
  end
endmodule

// File: rtl/bitClkRecovery.sv
module bitClkRecovery
  import bitClkPkg::*;
#(
  parameter int DIV_LEN      = 16,
  parameter int SEEK_LEN     = 15,
  parameter int EDGE_PHASE   = 8,
  parameter int WIN          = 2,
  parameter int LOSS_PERIODS = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic posRailN,
  output logic recClk,
  output logic seekMode
);
  localparam int CNT_W  = $clog2(DIV_LEN);
  localparam int MISS_W = $clog2(LOSS_PERIODS);

  ctrlStrobes_t      strb;
  logic              edgeSeen;
  logic              accept;
  logic              wrap;
  logic [CNT_W-1:0]  cnt;
  logic [MISS_W-1:0] missCnt;

  bitClkEdgeSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .railN(posRailN), .edgeSeen(edgeSeen)
  );

  bitClkCtrl #(
    .DIV_LEN(DIV_LEN), .EDGE_PHASE(EDGE_PHASE), .WIN(WIN), .LOSS_PERIODS(LOSS_PERIODS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .edgeSeen(edgeSeen), .cnt(cnt), .wrap(wrap),
    .strb(strb), .seekMode(seekMode), .accept(accept), .missCnt(missCnt)
  );

  bitClkDatapath #(
    .DIV_LEN(DIV_LEN), .SEEK_LEN(SEEK_LEN), .EDGE_PHASE(EDGE_PHASE)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .wrap(wrap), .recClk(recClk)
  );
endmodule

// File: rtl/bitClkRecoveryChk.sv
module bitClkRecoveryChk #(
  parameter int DIV_LEN      = 16,
  parameter int SEEK_LEN     = 15,
  parameter int EDGE_PHASE   = 8,
  parameter int WIN          = 2,
  parameter int LOSS_PERIODS = 16,
  localparam int CNT_W  = $clog2(DIV_LEN),
  localparam int MISS_W = $clog2(LOSS_PERIODS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              recClk,
  input logic              seekMode,
  input logic              edgeSeen,
  input logic              accept,
  input logic              wrap,
  input logic [CNT_W-1:0]  cnt,
  input logic [MISS_W-1:0] missCnt
);
  localparam logic [CNT_W-1:0]  LAST_LOCK = CNT_W'(DIV_LEN - 1);
  localparam logic [CNT_W-1:0]  LAST_SEEK = CNT_W'(SEEK_LEN - 1);
  localparam logic [CNT_W-1:0]  RESTART   = CNT_W'((EDGE_PHASE + 1) % DIV_LEN);
  localparam logic [CNT_W-1:0]  HALF      = CNT_W'(DIV_LEN / 2);
  localparam logic [CNT_W-1:0]  WIN_LO    = CNT_W'(EDGE_PHASE - WIN);
  localparam logic [CNT_W-1:0]  WIN_HI    = CNT_W'(EDGE_PHASE + WIN);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_PERIODS - 1);

  logic outside;
  assign outside = (cnt < WIN_LO) || (cnt > WIN_HI);

  assert_rise_at_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recClk) |-> cnt == '0);

  assert_fall_phase_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(recClk) |-> (cnt == HALF || (cnt == RESTART && $past(accept))));

  assert_lock_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!seekMode && !edgeSeen && cnt == LAST_LOCK) |=> cnt == '0);

  assert_seek_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seekMode && !edgeSeen && cnt == LAST_SEEK) |=> cnt == '0);

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!seekMode && edgeSeen && !outside) |=> cnt == RESTART);

  assert_outside_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!seekMode && edgeSeen && outside && cnt != LAST_LOCK) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_enter_seek_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seekMode) |-> ($past(missCnt) == MISS_LAST && $past(wrap)));

  assert_seek_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seekMode && edgeSeen) |=> (!seekMode && cnt == RESTART));
endmodule

bind bitClkRecovery bitClkRecoveryChk chkInst (
  .clk(clk), .rstN(rstN), .recClk(recClk), .seekMode(seekMode),
  .edgeSeen(edgeSeen), .accept(accept), .wrap(wrap), .cnt(cnt), .missCnt(missCnt)
);

// File: tb/tb_bitClkRecovery.sv
`timescale 1ns/1ps
module tb_bitClkRecovery;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic posRailN = 1'b1;
  logic recClk, seekMode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bitClkRecovery dut (.clk(clk), .rstN(rstN), .posRailN(posRailN),
                      .recClk(recClk), .seekMode(seekMode));

  // Reference model: state as it will be after the next rising edge has been applied.
  int mS1, mS2, mS3, mCnt, mSeek, mMiss, mRec;
  int cyc, lastRise, lastPeriod, prevRec;
  logic level;
  int ph, per;

  function automatic int winHit(int c);
    return (c >= 6 && c <= 10) ? 1 : 0;
  endfunction

  task automatic modelStep(input int x);
    int edgeNow, len, acc, wr;
    edgeNow = (mS3 == 1 && mS2 == 0) ? 1 : 0;
    len = (mSeek != 0) ? 15 : 16;
    acc = (edgeNow != 0 && (mSeek != 0 || winHit(mCnt) != 0)) ? 1 : 0;
    wr  = (acc == 0 && mCnt == len - 1) ? 1 : 0;
    if (acc != 0) begin
      mCnt = 9; mSeek = 0; mMiss = 0;
    end else begin
      mCnt = (wr != 0) ? 0 : mCnt + 1;
      if (mSeek != 0) mMiss = 0;
      else if (wr != 0) begin
        if (mMiss == 15) begin mSeek = 1; mMiss = 0; end
        else mMiss = mMiss + 1;
      end
    end
    mRec = (mCnt < 8) ? 1 : 0;
    mS3 = mS2; mS2 = mS1; mS1 = x;
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  // Compare, drive one input value, advance model, wait one cycle.
  task automatic tick(input logic x, input string req);
    check(req, int'(recClk), mRec, "recClk");
    check(req, int'(seekMode), mSeek, "seekMode");
    if (recClk && prevRec == 0) begin
      lastPeriod = cyc - lastRise;
      lastRise = cyc;
    end
    prevRec = int'(recClk);
    posRailN = x;
    level = x;
    modelStep(int'(x));
    cyc++;
    @(negedge clk);
  endtask

  task automatic hold(input logic x, input int n, input string req);
    for (int i = 0; i < n; i++) tick(x, req);
  endtask

  // Falling transition every 'per' cycles (per = base +/- jit); low for half a period.
  task automatic pattern(input int n, input int base, input int jit, input string req);
    per = base; ph = 0;
    for (int i = 0; i < n; i++) begin
      tick((ph < per / 2) ? 1'b0 : 1'b1, req);
      ph++;
      if (ph >= per) begin
        ph = 0;
        per = base + int'($urandom_range(0, 2 * jit)) - jit;
      end
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    mS1 = 1; mS2 = 1; mS3 = 1; mCnt = 0; mSeek = 1; mMiss = 0; mRec = 1;
    cyc = 0; lastRise = 0; lastPeriod = 0; prevRec = 1; level = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", int'(recClk), 1, "recClk after reset");
    check("R1", int'(seekMode), 1, "seekMode after reset");

    // R4: seek-mode free run has a 15-cycle period
    hold(1'b1, 80, "R4");
    check("R4", lastPeriod, 15, "seek period");

    // R2/R7: single falling transition in seek; acted on two edges later
    tick(1'b0, "R2");
    tick(1'b0, "R2");
    check("R7", int'(seekMode), 1, "seek before edge reaches counter");
    tick(1'b0, "R2");
    check("R7", int'(seekMode), 0, "seek cleared by transition");
    check("R2", int'(recClk), 0, "count restarted at 9");

    // R4: locked free run has a 16-cycle period (fewer than 16 periods silent)
    hold(1'b0, 100, "R4");
    check("R4", lastPeriod, 16, "locked period");
    check("R6", int'(seekMode), 0, "still locked after 6 silent periods");

    // R6: loss after 16 silent periods with the rail held low
    hold(1'b0, 200, "R6");
    check("R6", int'(seekMode), 1, "seek after 16 silent periods");

    // R8: a rising change does not exit seek
    hold(1'b1, 60, "R8");
    check("R8", int'(seekMode), 1, "rising change ignored");
    check("R8", lastPeriod, 15, "seek period kept");

    // R5: steady and jittered transitions keep lock
    pattern(200, 16, 0, "R5");
    check("R5", int'(seekMode), 0, "locked on clean stream");
    pattern(600, 16, 2, "R5");
    check("R5", int'(seekMode), 0, "lock held within window");

    // R6: silence after lock
    hold(1'b1, 16 * 16 + 20, "R6");
    check("R6", int'(seekMode), 1, "loss after silence");

    // Random mix: wider jitter reaches outside the window, plus silent gaps
    for (int k = 0; k < 12; k++) begin
      pattern(250, 13 + int'($urandom_range(0, 6)), int'($urandom_range(0, 3)), "R5");
      if ($urandom_range(0, 2) == 0) hold(1'b1, int'($urandom_range(20, 300)), "R6");
    end
    hold(level, 5, "R3");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule